// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block sits on the controller side of an SDRAM interface. It turns host-side requests for auto refresh, self refresh and power-down into command-bus patterns on the clock-enable and the three strobe lines. It also enforces the waiting times that must follow those commands before the device may accept another one. A single state machine owns the clock-enable pin. It issues refresh commands spaced by the row cycle time and gates power-down entry on a precharge guard timer plus a bank-status input. It also pulls the device out of power-down before the refresh interval can lapse.

The host holds a request line high for as long as it wants a service. A held refresh request produces a burst of refresh commands at the minimum legal spacing. The `ready` output tells the access logic that an ordinary command may be driven in the current cycle. While it is low, accesses wait and are not lost. Precharge commands are issued elsewhere and reported here through a one-cycle pulse.

Top module: `sdram_pwr_seq`

## Requirements
- R1: After reset, CKE is high, the command lines carry NOP (RAS#, CAS#, WE# = 1,1,1) and `ready` is high.
- R2: A refresh request sampled while idle drives one auto refresh command (CKE high, RAS#, CAS#, WE# = 0,0,1) in the next cycle. `ready` is low from that cycle until it rises exactly T_RC cycles after the refresh cycle.
- R3: While the refresh request stays high, auto refresh commands repeat exactly T_RC cycles apart, with NOP in every cycle between them.
- R4: A self-refresh request drives one cycle with CKE low and RAS#, CAS#, WE# = 0,0,1. After that cycle, CKE stays low with NOP for as long as the request is held. A refresh request during self refresh is ignored.
- R5: Dropping the self-refresh request raises CKE in the next cycle. `ready` returns exactly T_RC cycles after the cycle in which CKE rose, with NOP in between.
- R6: Power-down entry drops CKE with NOP on the lines. A precharge pulse in cycle p delays the earliest CKE fall to cycle p+T_RP+1.
- R7: Dropping the power-down request raises CKE in the next cycle with `ready` still low. `ready` rises one cycle later.
- R8: CKE stays low in power-down for at most PD_MAX consecutive cycles, after which the block forces an exit. After a forced exit, power-down is not re-entered until an auto refresh has been issued.
- R9: When several requests are sampled together, refresh wins over self refresh and self refresh wins over power-down.
- R10: A refresh request during power-down raises CKE in the next cycle and drives the auto refresh command one cycle after that.
- R11: While `banks_idle` is low, a power-down request leaves CKE high and `ready` high.
- R12: `ready` is never high in a cycle where CKE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_req | input | 1 | Auto refresh request, held high for a burst |
| sref_req | input | 1 | Self refresh request, level |
| pdn_req | input | 1 | Power-down request, level |
| banks_idle | input | 1 | All banks precharged |
| pre_done | input | 1 | One-cycle pulse when a precharge command is issued |
| cke | output | 1 | Clock enable to the device |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ready | output | 1 | An access command may be driven this cycle |

## Verification
The bench builds the block with T_RC = 4, T_RP = 3 and PD_MAX = 10. With these values, every timing window spans several cycles, so the bench can observe each boundary on both sides. A power-down limit of ten cycles brings the forced exit and the refresh-owed lockout into a short run. Ports are sampled one time unit after each rising edge, and every cycle offset is predicted from the requirement text.

// File: rtl/sdram_pwr_pkg.sv
package sdram_pwr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_AREF_WAIT, ST_SREF, ST_SREF_EXIT_WAIT, ST_PDN, ST_PDN_EXIT
  } seq_state_e;

  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_REF = 3'b001;
endpackage

// File: rtl/pwr_guard_timer.sv
module pwr_guard_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic         cnt_en;
  logic [W-1:0] cnt_d;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;
  assign cnt_d  = load ? load_val : cnt_q - W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdram_pwr_fsm.sv
module sdram_pwr_fsm
  import sdram_pwr_pkg::*;
#(
  parameter int T_RC   = 6,
  parameter int PD_MAX = 1000,
  parameter int CW     = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_req,
  input  logic          sref_req,
  input  logic          pdn_req,
  input  logic          banks_idle,
  input  logic          pre_done,
  input  logic          trp_zero,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          cke_q,
  output logic [2:0]    cmd_q,
  output logic          ready_q
);
  localparam logic [CW-1:0] RC_LOAD = CW'(T_RC - 1);
  localparam logic [CW-1:0] PD_LOAD = CW'(PD_MAX - 1);

  seq_state_e state_q, state_d;
  logic       cke_d, ready_d, owe_q, owe_d;
  logic [2:0] cmd_d;
  logic       pdn_ok;

  assign pdn_ok = banks_idle & trp_zero & ~pre_done;

  always_comb begin
    state_d  = state_q;
    cke_d    = 1'b1;
    cmd_d    = CMD_NOP;
    tmr_load = 1'b0;
    tmr_val  = RC_LOAD;
    owe_d    = owe_q;
    unique case (state_q)
      ST_SREF: begin
        cke_d = 1'b0;
        if (!sref_req) begin
          state_d  = ST_SREF_EXIT_WAIT;
          cke_d    = 1'b1;
          tmr_load = 1'b1;
        end
      end
      ST_PDN: begin
        cke_d = 1'b0;
        if (!pdn_req || ref_req || sref_req || tmr_zero) begin
          state_d = ST_PDN_EXIT;
          cke_d   = 1'b1;
          if (tmr_zero) owe_d = 1'b1;
        end
      end
      default: begin
        if (state_q == ST_IDLE || state_q == ST_PDN_EXIT || tmr_zero) begin
          if (ref_req) begin
            state_d  = ST_AREF_WAIT;
            cmd_d    = CMD_REF;
            tmr_load = 1'b1;
            owe_d    = 1'b0;
          end else if (sref_req) begin
            state_d = ST_SREF;
            cmd_d   = CMD_REF;
            cke_d   = 1'b0;
          end else if (pdn_req && pdn_ok && !owe_q) begin
            state_d  = ST_PDN;
            cke_d    = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = PD_LOAD;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
    endcase
    ready_d = (state_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cke_q   <= 1'b1;
      cmd_q   <= CMD_NOP;
      ready_q <= 1'b1;
      owe_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cke_q   <= cke_d;
      cmd_q   <= cmd_d;
      ready_q <= ready_d;
      owe_q   <= owe_d;
    end
  end

  // Checker state: cycles since last auto refresh and power-down residency.
  localparam int SW = $clog2(T_RC + 1);
  localparam int PW = $clog2(PD_MAX + 1);
  logic [SW-1:0] since_ref_q;
  logic [PW-1:0] pd_run_q;
  logic          is_aref;

  assign is_aref = cke_q && (cmd_q == CMD_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ref_q <= SW'(T_RC);
      pd_run_q    <= '0;
    end else begin
      if (is_aref)                    since_ref_q <= SW'(1);
      else if (since_ref_q < SW'(T_RC)) since_ref_q <= since_ref_q + SW'(1);
      if (state_q != ST_PDN)          pd_run_q <= '0;
      else if (pd_run_q < PW'(PD_MAX)) pd_run_q <= pd_run_q + PW'(1);
    end
  end

  a_r3_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    is_aref |-> since_ref_q >= SW'(T_RC));
  a_r2_ready_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> since_ref_q >= SW'(T_RC));
  a_r4_low_cke_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && cmd_q != CMD_NOP) |-> $fell(cke_q));
  a_r6_pdn_banks: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cke_q) && cmd_q == CMD_NOP) |-> $past(banks_idle));
  a_r7_exit_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_q) |-> !ready_q);
  a_r8_pd_residency: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PDN) |-> pd_run_q < PW'(PD_MAX));
  a_r12_low_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |-> !ready_q);
endmodule

// File: rtl/sdram_pwr_seq.sv
module sdram_pwr_seq #(
  parameter int T_RC   = 6,
  parameter int T_RP   = 3,
  parameter int PD_MAX = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_req,
  input  logic sref_req,
  input  logic pdn_req,
  input  logic banks_idle,
  input  logic pre_done,
  output logic cke,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready
);
  localparam int CW  = $clog2(((T_RC > PD_MAX) ? T_RC : PD_MAX) + 1);
  localparam int RPW = $clog2(T_RP + 1);

  logic          rst_meta_q, rst_sync_q;
  logic          tmr_load, tmr_zero, trp_zero;
  logic [CW-1:0] tmr_val;
  logic [2:0]    cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pwr_guard_timer #(.W(CW)) u_main_tmr (
    .clk(clk), .rst_n(rst_sync_q), .load(tmr_load),
    .load_val(tmr_val), .zero(tmr_zero)
  );

  pwr_guard_timer #(.W(RPW)) u_trp_tmr (
    .clk(clk), .rst_n(rst_sync_q), .load(pre_done),
    .load_val(RPW'(T_RP - 1)), .zero(trp_zero)
  );

  sdram_pwr_fsm #(.T_RC(T_RC), .PD_MAX(PD_MAX), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_sync_q),
    .ref_req(ref_req), .sref_req(sref_req), .pdn_req(pdn_req),
    .banks_idle(banks_idle), .pre_done(pre_done),
    .trp_zero(trp_zero), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .cke_q(cke), .cmd_q(cmd), .ready_q(ready)
  );

  assign {ras_n, cas_n, we_n} = cmd;
endmodule

// File: tb/sdram_pwr_seq_bench.sv
module sdram_pwr_seq_bench;
  localparam int TRC = 4;
  localparam int TRP = 3;
  localparam int PDM = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_req = 1'b0, sref_req = 1'b0, pdn_req = 1'b0;
  logic banks_idle = 1'b1, pre_done = 1'b0;
  logic cke, ras_n, cas_n, we_n, ready;
  int   checks = 0, errors = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  sdram_pwr_seq #(.T_RC(TRC), .T_RP(TRP), .PD_MAX(PDM)) u_sdram_pwr_seq (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .sref_req(sref_req),
    .pdn_req(pdn_req), .banks_idle(banks_idle), .pre_done(pre_done),
    .cke(cke), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ready(ready)
  );

  function automatic int cmd();
    return int'({ras_n, cas_n, we_n});
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 60 && !ready; i++) tick();
  endtask

  task automatic t_reset();
    chk(cke == 1'b1, "R1 cke", cke, 1);
    chk(cmd() == 7, "R1 cmd", cmd(), 7);
    chk(ready == 1'b1, "R1 ready", ready, 1);
  endtask

  task automatic t_single_ref();
    ref_req = 1'b1;
    tick();
    chk(cmd() == 1 && cke, "R2 aref cmd", cmd(), 1);
    chk(!ready, "R2 ready low at aref", ready, 0);
    ref_req = 1'b0;
    for (int k = 1; k < TRC; k++) begin
      tick();
      chk(!ready && cmd() == 7, "R2 wait window", ready, 0);
    end
    tick();
    chk(ready, "R2 ready back", ready, 1);
  endtask

  task automatic t_burst();
    ref_req = 1'b1;
    tick();
    chk(cmd() == 1, "R3 first aref", cmd(), 1);
    for (int n = 0; n < 2; n++) begin
      for (int k = 1; k < TRC; k++) begin
        tick();
        chk(cmd() == 7, "R3 nop between", cmd(), 7);
      end
      tick();
      chk(cmd() == 1 && cke, "R3 next aref", cmd(), 1);
    end
    ref_req = 1'b0;
    wait_ready();
  endtask

  task automatic t_sref();
    sref_req = 1'b1;
    tick();
    chk(!cke && cmd() == 1, "R4 sref entry", cmd(), 1);
    ref_req = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk(!cke && cmd() == 7, "R4 sref hold ignores refresh", cmd(), 7);
    end
    ref_req = 1'b0;
    tick();
    sref_req = 1'b0;
    tick();
    chk(cke && !ready, "R5 cke high on exit", cke, 1);
    for (int k = 1; k < TRC; k++) begin
      tick();
      chk(!ready && cmd() == 7, "R5 exit wait", ready, 0);
    end
    tick();
    chk(ready, "R5 ready after exit wait", ready, 1);
  endtask

  task automatic t_pdn_trp();
    pre_done = 1'b1;
    pdn_req = 1'b1;
    tick();
    pre_done = 1'b0;
    for (int k = 1; k <= TRP; k++) begin
      chk(cke, "R6 cke held during precharge guard", cke, 1);
      tick();
    end
    chk(!cke && cmd() == 7, "R6 pdn entry at p+T_RP+1", cke, 0);
    tick();
    pdn_req = 1'b0;
    tick();
    chk(cke && !ready, "R7 exit cycle", ready, 0);
    tick();
    chk(ready, "R7 ready after exit", ready, 1);
  endtask

  task automatic t_banks_busy();
    banks_idle = 1'b0;
    pdn_req = 1'b1;
    for (int k = 0; k < 6; k++) begin
      tick();
      chk(cke && ready, "R11 busy banks block pdn", cke, 1);
    end
    banks_idle = 1'b1;
    tick();
    chk(!cke, "R11 pdn once banks idle", cke, 0);
    chk(!ready, "R12 not ready in pdn", ready, 0);
    pdn_req = 1'b0;
    tick(); tick();
  endtask

  task automatic t_forced();
    int low;
    pdn_req = 1'b1;
    tick();
    low = 0;
    for (int k = 0; k < 40 && !cke; k++) begin
      low++;
      tick();
    end
    chk(low == PDM, "R8 residency limit", low, PDM);
    for (int k = 0; k < 6; k++) begin
      tick();
      chk(cke, "R8 no re-entry before refresh", cke, 1);
    end
    ref_req = 1'b1;
    tick();
    chk(cmd() == 1, "R8 refresh after forced exit", cmd(), 1);
    ref_req = 1'b0;
    for (int k = 0; k < TRC + 2 && cke; k++) tick();
    chk(!cke, "R8 re-entry after refresh", cke, 0);
    pdn_req = 1'b0;
    tick();
    wait_ready();
  endtask

  task automatic t_prio();
    ref_req = 1'b1; sref_req = 1'b1; pdn_req = 1'b1;
    tick();
    chk(cke && cmd() == 1, "R9 refresh first", cmd(), 1);
    ref_req = 1'b0;
    for (int k = 1; k < TRC; k++) tick();
    tick();
    chk(!cke && cmd() == 1, "R9 self refresh over power-down", cmd(), 1);
    sref_req = 1'b0; pdn_req = 1'b0;
    tick();
    wait_ready();
  endtask

  task automatic t_pdn_ref();
    pdn_req = 1'b1;
    tick();
    chk(!cke, "R10 in pdn", cke, 0);
    tick();
    ref_req = 1'b1;
    tick();
    chk(cke && cmd() == 7 && !ready, "R10 exit cycle", cke, 1);
    tick();
    chk(cke && cmd() == 1, "R10 refresh after exit", cmd(), 1);
    ref_req = 1'b0; pdn_req = 1'b0;
    wait_ready();
    chk(ready, "R10 ready at end", ready, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_single_ref();
    t_burst();
    t_sref();
    t_pdn_trp();
    t_banks_busy();
    t_forced();
    t_prio();
    t_pdn_ref();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule